// File: doc/BRIEF.md
# Dual Sample FIFO with CPU and DMA Fill Levels

This block buffers conversion results from a sampling sequencer in two independent first-in first-out queues. The sequencer pushes one already-tagged word per cycle through a valid/data port and names the target queue with a select bit. A CPU or a DMA engine drains either queue through a register-style read strobe. The read word appears on a shared output one cycle later.

Each queue tracks its own occupancy, which is visible at all times as a word count. It has two fill levels that are programmed separately. The CPU level produces a one-cycle event when the count reaches it. The DMA level drives a request line that stays high while enough words are waiting, but only when that queue's DMA line is enabled. A push into a full queue and a pop from an empty queue are each reported as a one-cycle pulse, and neither one disturbs the stored data.

Top module: `sampleFifoPair`

## Requirements
- R1: Out of reset every queue is empty, so wordCount is 0 and all event and request outputs are low. Each queue holds at most DEPTH (64) words, and wordCount always shows the number of words stored in that queue.
- R2: A push with wrValid high stores wrData in the queue that wrSel selects (0 or 1). A read strobe pops the oldest word of the queue that rdSel selects and shows it on rdData after the next clock edge. rdData keeps its value until the next read strobe.
- R3: A push into a full queue drops the new word, keeps the stored words and the count unchanged, and pulses that queue's overrun bit for one cycle after the edge.
- R4: A read strobe on an empty queue leaves the count unchanged, drives rdData to zero, and pulses that queue's underflow bit for one cycle after the edge.
- R5: cpuEvent of a queue pulses for one cycle when the condition "wordCount >= CPU level" goes from false to true. This can happen through a push or through a new level being programmed.
- R6: dmaReq of a queue is high while its wordCount is at or above its DMA level and its DMA line is enabled. It falls in the cycle after the count drops below the level.
- R7: While dmaEnable of a queue is low, its dmaReq stays low whatever the count.
- R8: A write with cfgWrite high sets the level named by cfgKind (0 = CPU level, 1 = DMA level) of the queue that cfgSel selects. A value outside 1..64 is ignored and the old level is kept. Both levels reset to 32.
- R9: The two queues are independent. Traffic, levels and events on one queue never change the count or outputs of the other.
- R10: A push and a pop on the same non-empty, non-full queue in the same cycle leave its count unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Push strobe from the sequencer |
| wrSel | input | 1 | Target queue of the push |
| wrData | input | 16 | Tagged sample word |
| rdStrobe | input | 1 | Pop strobe from CPU or DMA |
| rdSel | input | 1 | Queue to pop |
| rdData | output | 16 | Popped word, valid the cycle after the strobe |
| cfgWrite | input | 1 | Level programming strobe |
| cfgSel | input | 1 | Queue whose level is written |
| cfgKind | input | 1 | 0 = CPU level, 1 = DMA level |
| cfgValue | input | 8 | New level, accepted only in 1..64 |
| dmaEnable | input | 2 | Per-queue DMA line enable |
| wordCount | output | 2x7 | Per-queue stored word count |
| cpuEvent | output | 2 | Per-queue CPU level event pulse |
| dmaReq | output | 2 | Per-queue DMA request level |
| overrun | output | 2 | Per-queue push-while-full pulse |
| underflow | output | 2 | Per-queue pop-while-empty pulse |

## Verification
Every result of this block comes from the single register stage behind the inputs. That covers wordCount, rdData, cpuEvent, dmaReq, overrun and underflow, so each one is due exactly one rising edge after the cycle in which the push, pop, level write or enable change is presented. The bench drives a whole cycle of inputs on the falling edge, lets one rising edge pass, and compares every output on the following falling edge against a reference queue model. That model advances by one step per edge, and the comparison is made after that step. A level write and a push in the same cycle therefore both count toward the same expected event.

// File: rtl/sampleFifoPkg.sv
package sampleFifoPkg;

  // Strobes from the occupancy control to the storage datapath.
  typedef struct packed {
    logic push;      // accepted write
    logic pop;       // accepted read
    logic popEmpty;  // read of an empty queue: output zero
  } fifoStrobe_t;

  typedef enum logic {
    LVL_CPU = 1'b0,
    LVL_DMA = 1'b1
  } levelKind_e;

endpackage

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import sampleFifoPkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int CNT_W       = 7,
  parameter int CFG_W       = 8,
  parameter int RESET_LEVEL = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             cfgWrite,
  input  levelKind_e       cfgKind,
  input  logic [CFG_W-1:0] cfgValue,
  input  logic             dmaEnable,
  output logic [CNT_W-1:0] count,
  output logic             cpuEvent,
  output logic             dmaReq,
  output logic             overrun,
  output logic             underflow,
  output fifoStrobe_t      strobe
);

  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CFG_W-1:0] MAX_LEVEL = CFG_W'(DEPTH);
  localparam logic [CNT_W-1:0] RST_LVL   = CNT_W'(RESET_LEVEL);

  logic [CNT_W-1:0] cpuLevel, dmaLevel;
  logic [CNT_W-1:0] countNext, cpuLevelNext, dmaLevelNext;
  logic             aboveCpu, aboveCpuNext;
  logic             levelOk, isFull, isEmpty;

  always_comb begin
    isFull  = (count == FULL_CNT);
    isEmpty = (count == '0);

    strobe.push     = wrEn && !isFull;
    strobe.pop      = rdEn && !isEmpty;
    strobe.popEmpty = rdEn && isEmpty;

    countNext = count;
    if (strobe.push && !strobe.pop) begin
      countNext = count + CNT_W'(1);
    end else if (strobe.pop && !strobe.push) begin
      countNext = count - CNT_W'(1);
    end

    // Out-of-range levels are dropped, the old setting stays.
    levelOk      = cfgWrite && (cfgValue != '0) && (cfgValue <= MAX_LEVEL);
    cpuLevelNext = (levelOk && cfgKind == LVL_CPU) ? CNT_W'(cfgValue) : cpuLevel;
    dmaLevelNext = (levelOk && cfgKind == LVL_DMA) ? CNT_W'(cfgValue) : dmaLevel;

    aboveCpuNext = (countNext >= cpuLevelNext);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      cpuLevel  <= RST_LVL;
      dmaLevel  <= RST_LVL;
      aboveCpu  <= 1'b0;
      cpuEvent  <= 1'b0;
      dmaReq    <= 1'b0;
      overrun   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      count     <= countNext;
      cpuLevel  <= cpuLevelNext;
      dmaLevel  <= dmaLevelNext;
      aboveCpu  <= aboveCpuNext;
      cpuEvent  <= aboveCpuNext && !aboveCpu;
      dmaReq    <= dmaEnable && (countNext >= dmaLevelNext);
      overrun   <= wrEn && isFull;
      underflow <= strobe.popEmpty;
    end
  end

endmodule

// File: rtl/fifoStore.sv
module fifoStore
  import sampleFifoPkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] readWord
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      mem[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      readWord <= '0;
    end else begin
      if (strobe.push) begin
        wrPtr <= bump(wrPtr);
      end
      if (strobe.pop) begin
        rdPtr    <= bump(rdPtr);
        readWord <= mem[rdPtr];
      end else if (strobe.popEmpty) begin
        readWord <= '0;
      end
    end
  end

endmodule

// File: rtl/sampleFifoPair.sv
module sampleFifoPair
  import sampleFifoPkg::*;
#(
  parameter int NUM_FIFOS   = 2,
  parameter int DEPTH       = 64,
  parameter int DATA_W      = 16,
  parameter int CFG_W       = 8,
  parameter int RESET_LEVEL = 32,
  localparam int SEL_W      = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrValid,
  input  logic [SEL_W-1:0]                wrSel,
  input  logic [DATA_W-1:0]               wrData,
  input  logic                            rdStrobe,
  input  logic [SEL_W-1:0]                rdSel,
  output logic [DATA_W-1:0]               rdData,
  input  logic                            cfgWrite,
  input  logic [SEL_W-1:0]                cfgSel,
  input  logic                            cfgKind,
  input  logic [CFG_W-1:0]                cfgValue,
  input  logic [NUM_FIFOS-1:0]            dmaEnable,
  output logic [NUM_FIFOS-1:0][CNT_W-1:0] wordCount,
  output logic [NUM_FIFOS-1:0]            cpuEvent,
  output logic [NUM_FIFOS-1:0]            dmaReq,
  output logic [NUM_FIFOS-1:0]            overrun,
  output logic [NUM_FIFOS-1:0]            underflow
);

  fifoStrobe_t       strobes [NUM_FIFOS];
  logic [DATA_W-1:0] words   [NUM_FIFOS];
  logic [SEL_W-1:0]  lastSel;

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_lane
    logic laneWr, laneRd, laneCfg;
    assign laneWr  = wrValid  && (wrSel  == SEL_W'(g));
    assign laneRd  = rdStrobe && (rdSel  == SEL_W'(g));
    assign laneCfg = cfgWrite && (cfgSel == SEL_W'(g));

    fifoCtrl #(
      .DEPTH(DEPTH), .CNT_W(CNT_W), .CFG_W(CFG_W), .RESET_LEVEL(RESET_LEVEL)
    ) i_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (laneWr),
      .rdEn      (laneRd),
      .cfgWrite  (laneCfg),
      .cfgKind   (levelKind_e'(cfgKind)),
      .cfgValue  (cfgValue),
      .dmaEnable (dmaEnable[g]),
      .count     (wordCount[g]),
      .cpuEvent  (cpuEvent[g]),
      .dmaReq    (dmaReq[g]),
      .overrun   (overrun[g]),
      .underflow (underflow[g]),
      .strobe    (strobes[g])
    );

    fifoStore #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)
    ) i_store (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobes[g]),
      .wrData   (wrData),
      .readWord (words[g])
    );
  end

  // Remember which queue was read so the shared output follows it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSel <= '0;
    end else if (rdStrobe) begin
      lastSel <= rdSel;
    end
  end

  assign rdData = words[lastSel];

endmodule

// File: rtl/sampleFifoPairChecker.sv
module sampleFifoPairChecker #(
  parameter int NUM_FIFOS = 2,
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 7
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [DATA_W-1:0]               rdData,
  input logic [NUM_FIFOS-1:0]            dmaEnable,
  input logic [NUM_FIFOS-1:0][CNT_W-1:0] wordCount,
  input logic [NUM_FIFOS-1:0]            cpuEvent,
  input logic [NUM_FIFOS-1:0]            dmaReq,
  input logic [NUM_FIFOS-1:0]            overrun,
  input logic [NUM_FIFOS-1:0]            underflow
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_chk
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
      wordCount[g] <= FULL_CNT);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
      (wordCount[g] == $past(wordCount[g])) ||
      (wordCount[g] == $past(wordCount[g]) + CNT_W'(1)) ||
      (wordCount[g] == $past(wordCount[g]) - CNT_W'(1)));

    assert_overrun_full_R3: assert property (@(posedge clk) disable iff (!rstN)
      overrun[g] |-> ($past(wordCount[g]) == FULL_CNT));

    assert_underflow_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      underflow[g] |-> (($past(wordCount[g]) == '0) && (rdData == '0)));

    assert_cpu_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
      cpuEvent[g] |=> !cpuEvent[g]);

    assert_dma_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
      dmaReq[g] |-> $past(dmaEnable[g]));

    assert_dma_nonempty_R6: assert property (@(posedge clk) disable iff (!rstN)
      dmaReq[g] |-> (wordCount[g] != '0));
  end

endmodule

bind sampleFifoPair sampleFifoPairChecker #(
  .NUM_FIFOS(NUM_FIFOS), .DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_sampleFifoPairChecker (
  .clk       (clk),
  .rstN      (rstN),
  .rdData    (rdData),
  .dmaEnable (dmaEnable),
  .wordCount (wordCount),
  .cpuEvent  (cpuEvent),
  .dmaReq    (dmaReq),
  .overrun   (overrun),
  .underflow (underflow)
);

// File: tb/test_sampleFifoPair.sv
module test_sampleFifoPair;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_FIFOS  = 2;
  localparam int DEPTH      = 64;
  localparam int DATA_W     = 16;
  localparam int CFG_W      = 8;
  localparam int CNT_W      = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, wrSel = 1'b0, rdStrobe = 1'b0, rdSel = 1'b0;
  logic cfgWrite = 1'b0, cfgSel = 1'b0, cfgKind = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [CFG_W-1:0]  cfgValue = '0;
  logic [NUM_FIFOS-1:0] dmaEnable = '0;
  logic [DATA_W-1:0] rdData;
  logic [NUM_FIFOS-1:0][CNT_W-1:0] wordCount;
  logic [NUM_FIFOS-1:0] cpuEvent, dmaReq, overrun, underflow;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sampleFifoPair i_sampleFifoPair (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSel(wrSel), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdSel(rdSel), .rdData(rdData), .cfgWrite(cfgWrite),
    .cfgSel(cfgSel), .cfgKind(cfgKind), .cfgValue(cfgValue), .dmaEnable(dmaEnable),
    .wordCount(wordCount), .cpuEvent(cpuEvent), .dmaReq(dmaReq),
    .overrun(overrun), .underflow(underflow)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  string phaseTag = "R1";

  // Reference model state
  logic [DATA_W-1:0] modelQ [NUM_FIFOS][$];
  int  cpuLvlM [NUM_FIFOS];
  int  dmaLvlM [NUM_FIFOS];
  bit  aboveM  [NUM_FIFOS];
  bit  expCpu  [NUM_FIFOS];
  bit  expDma  [NUM_FIFOS];
  bit  expOvr  [NUM_FIFOS];
  bit  expUnd  [NUM_FIFOS];
  int  expRd = 0;

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s (%s) at %0t: actual=%0d expected=%0d", tag, phaseTag, $time, act, exp);
    end
  endtask

  function automatic bit levelValid(int v);
    return (v >= 1) && (v <= DEPTH);
  endfunction

  task automatic modelStep();
    for (int i = 0; i < NUM_FIFOS; i++) begin
      bit wr = wrValid && (int'(wrSel) == i);
      bit rd = rdStrobe && (int'(rdSel) == i);
      int sz = modelQ[i].size();
      int nsz;
      bit ab;
      expOvr[i] = wr && (sz == DEPTH);
      expUnd[i] = rd && (sz == 0);
      if (rd) expRd = (sz > 0) ? int'(modelQ[i].pop_front()) : 0;
      if (wr && sz < DEPTH) modelQ[i].push_back(wrData);
      if (cfgWrite && int'(cfgSel) == i && levelValid(int'(cfgValue))) begin
        if (cfgKind == 1'b0) cpuLvlM[i] = int'(cfgValue);
        else                 dmaLvlM[i] = int'(cfgValue);
      end
      nsz = modelQ[i].size();
      ab = (nsz >= cpuLvlM[i]);
      expCpu[i] = ab && !aboveM[i];
      aboveM[i] = ab;
      expDma[i] = dmaEnable[i] && (nsz >= dmaLvlM[i]);
    end
  endtask

  task automatic compareAll();
    for (int i = 0; i < NUM_FIFOS; i++) begin
      check("R1 wordCount", int'(wordCount[i]), modelQ[i].size());
      check("R5 cpuEvent",  int'(cpuEvent[i]),  int'(expCpu[i]));
      check("R6 dmaReq",    int'(dmaReq[i]),    int'(expDma[i]));
      check("R3 overrun",   int'(overrun[i]),   int'(expOvr[i]));
      check("R4 underflow", int'(underflow[i]), int'(expUnd[i]));
    end
    check("R2 rdData", int'(rdData), expRd);
  endtask

  // One bus cycle: inputs set on the falling edge, results due after one rising edge.
  task automatic step(bit wv, bit ws, logic [DATA_W-1:0] wd, bit rs, bit rsl,
                      bit cw, bit cs, bit ck, int cv);
    wrValid = wv; wrSel = ws; wrData = wd;
    rdStrobe = rs; rdSel = rsl;
    cfgWrite = cw; cfgSel = cs; cfgKind = ck; cfgValue = CFG_W'(cv);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    step(0, 0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic push(bit q, logic [DATA_W-1:0] d);
    step(1, q, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pop(bit q);
    step(0, 0, '0, 1, q, 0, 0, 0, 0);
  endtask

  task automatic setLevel(bit q, bit kind, int v);
    step(0, 0, '0, 0, 0, 1, q, kind, v);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NUM_FIFOS; i++) begin
      cpuLvlM[i] = 32; dmaLvlM[i] = 32; aboveM[i] = 0;
      expCpu[i] = 0; expDma[i] = 0; expOvr[i] = 0; expUnd[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    phaseTag = "R1";
    compareAll();

    // R8: out-of-range levels are ignored, then a valid one takes effect
    phaseTag = "R8";
    setLevel(0, 0, 0);
    setLevel(0, 0, 65);
    setLevel(0, 0, 200);
    for (int k = 0; k < 5; k++) push(0, DATA_W'(16'h100 + k));
    setLevel(0, 0, 4);   // count 5 >= 4 now: event on the level write
    setLevel(0, 1, 8);
    dmaEnable = 2'b01;

    // R9: fill queue 0 to full, queue 1 stays empty
    phaseTag = "R9";
    for (int k = 5; k < DEPTH; k++) push(0, DATA_W'(16'h100 + k));
    // R3: pushes into a full queue
    phaseTag = "R3";
    push(0, 16'hDEAD);
    push(0, 16'hBEEF);
    // R7: DMA line off while above level
    phaseTag = "R7";
    dmaEnable = 2'b00;
    idle();
    idle();
    dmaEnable = 2'b01;
    idle();
    // R2/R6: drain in order, request falls below level
    phaseTag = "R2";
    for (int k = 0; k < DEPTH; k++) pop(0);
    // R4: underflow reads
    phaseTag = "R4";
    pop(0);
    pop(1);
    // R10: push and pop on the same queue in one cycle
    phaseTag = "R10";
    for (int k = 0; k < 5; k++) push(1, DATA_W'(16'h200 + k));
    step(1, 1, 16'h2FF, 1, 1, 0, 0, 0, 0);
    step(1, 1, 16'h2FE, 1, 1, 0, 0, 0, 0);

    // Random traffic with changing bias
    phaseTag = "R9";
    for (int blk = 0; blk < 8; blk++) begin
      int wrPct = (blk % 2 == 0) ? 80 : 25;
      int rdPct = (blk % 2 == 0) ? 25 : 80;
      for (int c = 0; c < 500; c++) begin
        bit cw = ($urandom_range(0, 99) < 4);
        dmaEnable = ($urandom_range(0, 99) < 10) ? NUM_FIFOS'($urandom) : dmaEnable;
        step($urandom_range(0, 99) < wrPct, 1'($urandom), DATA_W'($urandom),
             $urandom_range(0, 99) < rdPct, 1'($urandom),
             cw, 1'($urandom), 1'($urandom), int'($urandom_range(0, 70)));
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule